// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous host and a 32K x 8 asynchronous static RAM. The host presents one read or one write at a time over a request/ready handshake. The controller then produces the chip-select, output-enable and write-enable strobes together with the address and the write data, all from registers. For a read it captures the returned byte and presents it with a one-cycle valid strobe. Every timing minimum is a parameter in nanoseconds. Each one is converted to a whole number of clock cycles by rounding up against the clock-period parameter.

A retention input parks the memory in the deselected state so its supply can be lowered. New accesses stay blocked while the input is high. They also stay blocked for a long recovery window after it falls. An access already under way when retention is raised runs to completion first. Writes are strobed by write-enable with output-enable held high. A read is always followed by a short bus turnaround, so the controller never drives data while the memory may still be driving its outputs.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, and until the first accepted request, chip-select, output-enable and write-enable are high, the data drive enable is low and the read-valid strobe is low; after reset, with retention low, ready is high.
- R2: An accepted read holds chip-select and output-enable low and write-enable high for RD = max(ceil(tRC/Tclk), ceil(tAA/Tclk), ceil(tOE/Tclk)) cycles. The address stays constant and the data drive stays off for all of these cycles.
- R3: Read data is captured at the clock edge that ends the last read cycle. It appears on the read data output in the next cycle, together with read-valid high for exactly that one cycle.
- R4: An accepted write holds chip-select and write-enable low, output-enable high and the data drive on for WP = max(ceil(tWP/Tclk), ceil(tDW/Tclk), ceil(tAW/Tclk)) cycles, with the address and the write data constant.
- R5: After write-enable rises, chip-select stays low and the address, the data and the drive are held for WC - WP cycles, where WC = max(ceil(tWC/Tclk), WP + 1). The written byte is what a later read of that address returns.
- R6: After a read, chip-select and output-enable are high and the drive is off for TURN = max(1, ceil(tOHZ/Tclk)) cycles before ready can rise again.
- R7: Ready is high only when no access, turnaround, retention or recovery is in progress and retention is low. A request is accepted at a clock edge only while ready is high. A request held while ready is low causes no memory strobe.
- R8: When retention is high, the controller deselects the memory once any access in progress has finished, and it keeps the memory deselected while retention stays high.
- R9: After retention falls, ready stays low for REC = ceil(tREC/Tclk) cycles. If retention rises again during that window, the count restarts from the next fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| rd_data | output | DATA_W | Byte returned by a read |
| retain | input | 1 | Retention request: deselect and block access |
| mem_addr | output | ADDR_W | Address lines to the memory |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the data bus tristate drivers |
| mem_dq_i | input | DATA_W | Data from the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The memory model in the bench shows valid read data only after the address and both strobes have been stable for the full read length. A read sampled even one cycle early therefore returns a wrong byte, and the same applies to a write whose tail is missing. Back-to-back writes, read-after-write and write-after-read to the same address separate correct pulse lengths and turnaround from sequences that only look right in isolation. The corner addresses 0 and 0x7FFF and the data values 0x00, 0xFF and alternating-bit patterns show whether address and data bits are dropped or stuck. Requests held across retention and across the recovery window, together with retention raised during an access and re-raised during recovery, separate a correct lockout from one that accepts early or aborts a transfer.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WPULSE,
      ST_WTAIL,
      ST_TURN,
      ST_RETAIN,
      ST_RECOVER
   } ctrl_state_e;

   // registered strobe set driven to the memory pins
   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic drive;
   } pin_ctl_t;

   localparam pin_ctl_t PIN_IDLE  = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
   localparam pin_ctl_t PIN_READ  = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
   localparam pin_ctl_t PIN_WLOW  = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
   localparam pin_ctl_t PIN_WHOLD = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};

   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned RD_CYC   = 5,
   parameter int unsigned WP_CYC   = 4,
   parameter int unsigned WT_CYC   = 1,
   parameter int unsigned TURN_CYC = 2,
   parameter int unsigned REC_CYC  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             retain,
   input  logic             t_expired,
   output logic             t_load,
   output logic [CNT_W-1:0] t_load_val,
   output logic             req_ready,
   output logic             accept,
   output logic             capture,
   output pin_ctl_t         ctl_nxt
);

   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] WT_LD   = CNT_W'(WT_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

   ctrl_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign req_ready = (state_q == ST_IDLE) && !retain;

   always_comb begin
      state_d    = state_q;
      t_load     = 1'b0;
      t_load_val = '0;
      accept     = 1'b0;
      capture    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (retain) begin
               state_d = ST_RETAIN;
            end else if (req_valid) begin
               accept = 1'b1;
               t_load = 1'b1;
               if (req_write) begin
                  state_d    = ST_WPULSE;
                  t_load_val = WP_LD;
               end else begin
                  state_d    = ST_READ;
                  t_load_val = RD_LD;
               end
            end
         end
         ST_READ: begin
            if (t_expired) begin
               capture    = 1'b1;
               state_d    = ST_TURN;
               t_load     = 1'b1;
               t_load_val = TURN_LD;
            end
         end
         ST_WPULSE: begin
            if (t_expired) begin
               state_d    = ST_WTAIL;
               t_load     = 1'b1;
               t_load_val = WT_LD;
            end
         end
         ST_WTAIL, ST_TURN: begin
            if (t_expired) state_d = ST_IDLE;
         end
         ST_RETAIN: begin
            if (!retain) begin
               state_d    = ST_RECOVER;
               t_load     = 1'b1;
               t_load_val = REC_LD;
            end
         end
         ST_RECOVER: begin
            if (retain)         state_d = ST_RETAIN;
            else if (t_expired) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // pin levels follow the state being entered, so they leave a flop
   always_comb begin
      unique case (state_d)
         ST_READ:   ctl_nxt = PIN_READ;
         ST_WPULSE: ctl_nxt = PIN_WLOW;
         ST_WTAIL:  ctl_nxt = PIN_WHOLD;
         default:   ctl_nxt = PIN_IDLE;
      endcase
   end

   // R9: a lockout state never hands out a grant
   assert_lockout_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RETAIN || state_q == ST_RECOVER) |-> !req_ready);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W         = 15,
   parameter int unsigned DATA_W         = 8,
   parameter bit          RESET_DATAPATH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  pin_ctl_t          ctl_nxt,
   input  logic              capture,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output pin_ctl_t          ctl_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= PIN_IDLE;
         rd_valid <= 1'b0;
      end else begin
         ctl_q    <= ctl_nxt;
         rd_valid <= capture;
      end
   end

   generate
      if (RESET_DATAPATH) begin : g_dp_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_addr <= '0;
               mem_dq_o <= '0;
               rd_data  <= '0;
            end else begin
               if (accept) begin
                  mem_addr <= req_addr;
                  mem_dq_o <= req_wdata;
               end
               if (capture) rd_data <= mem_dq_i;
            end
         end
      end else begin : g_dp_norst
         always_ff @(posedge clk) begin
            if (accept) begin
               mem_addr <= req_addr;
               mem_dq_o <= req_wdata;
            end
            if (capture) rd_data <= mem_dq_i;
         end
      end
   endgenerate

   // R3: read data is presented for a single cycle
   assert_rdvalid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W         = 15,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned CLK_NS         = 20,
   parameter int unsigned T_RC_NS        = 100,
   parameter int unsigned T_AA_NS        = 100,
   parameter int unsigned T_OE_NS        = 50,
   parameter int unsigned T_WC_NS        = 100,
   parameter int unsigned T_WP_NS        = 60,
   parameter int unsigned T_DW_NS        = 35,
   parameter int unsigned T_AW_NS        = 80,
   parameter int unsigned T_OHZ_NS       = 40,
   parameter int unsigned T_REC_NS       = 5_000_000,
   parameter bit          RESET_DATAPATH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              retain,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n
);

   localparam int unsigned RD_CYC = umax(umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                         umax(ns_to_cyc(T_OE_NS, CLK_NS), 1));
   localparam int unsigned WP_CYC = umax(umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                         umax(ns_to_cyc(T_AW_NS, CLK_NS), 1));
   localparam int unsigned WC_CYC   = umax(ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC + 1);
   localparam int unsigned WT_CYC   = WC_CYC - WP_CYC;
   localparam int unsigned TURN_CYC = umax(ns_to_cyc(T_OHZ_NS, CLK_NS), 1);
   localparam int unsigned REC_CYC  = umax(ns_to_cyc(T_REC_NS, CLK_NS), 1);
   localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WC_CYC), umax(TURN_CYC, REC_CYC));
   localparam int unsigned CNT_W    = umax($clog2(MAX_CYC + 1), 1);

   initial begin
      assert (CLK_NS > 0) else $error("clock period must be non-zero");
      assert (ADDR_W > 0 && ADDR_W <= 32) else $error("address width out of range");
      assert (DATA_W > 0) else $error("data width must be non-zero");
      assert (WT_CYC >= 1) else $error("write tail must last at least one cycle");
   end

   logic             t_load, t_expired, accept, capture;
   logic [CNT_W-1:0] t_load_val;
   pin_ctl_t         ctl_nxt, ctl_q;

   sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_load_val),
      .expired  (t_expired)
   );

   sram_ctrl_seq #(
      .CNT_W    (CNT_W),
      .RD_CYC   (RD_CYC),
      .WP_CYC   (WP_CYC),
      .WT_CYC   (WT_CYC),
      .TURN_CYC (TURN_CYC),
      .REC_CYC  (REC_CYC)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .retain     (retain),
      .t_expired  (t_expired),
      .t_load     (t_load),
      .t_load_val (t_load_val),
      .req_ready  (req_ready),
      .accept     (accept),
      .capture    (capture),
      .ctl_nxt    (ctl_nxt)
   );

   sram_ctrl_pins #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .RESET_DATAPATH (RESET_DATAPATH)
   ) pins_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .ctl_nxt   (ctl_nxt),
      .capture   (capture),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .ctl_q     (ctl_q),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   assign mem_ce_n  = ctl_q.ce_n;
   assign mem_oe_n  = ctl_q.oe_n;
   assign mem_we_n  = ctl_q.we_n;
   assign mem_dq_oe = ctl_q.drive;

   // R4: a write strobe always comes with select, output disabled and data driven
   assert_write_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

   // R2: the bus is never driven while the memory outputs are enabled
   assert_read_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   // R5: address stays put for as long as the chip stays selected
   assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R6: no drive in the cycle after the output enable is removed
   assert_turn_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_oe_n && $past(!mem_oe_n)) |-> (!mem_dq_oe && mem_ce_n));

   // R7: a selected memory means the host is held off
   assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   // R8: retention keeps an already deselected memory deselected
   assert_retain_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (retain && $past(retain) && $past(mem_ce_n)) |-> mem_ce_n);

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

   localparam int CLKNS = 8;
   localparam int RC = 100, AA = 100, OEN = 50, WC = 100, WPN = 60, DW = 35, AW = 80, OHZ = 40, RECN = 2000;

   function automatic int cdiv(input int n);
      return (n + CLKNS - 1) / CLKNS;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int RD_N   = mx(mx(cdiv(RC), cdiv(AA)), cdiv(OEN));
   localparam int WP_N   = mx(mx(cdiv(WPN), cdiv(DW)), cdiv(AW));
   localparam int WC_N   = mx(cdiv(WC), WP_N + 1);
   localparam int TAIL_N = WC_N - WP_N;
   localparam int TURN_N = mx(cdiv(OHZ), 1);
   localparam int REC_N  = cdiv(RECN);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, retain = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
   logic [7:0]  rd_data, mem_dq_o;
   logic [7:0]  mem_dq_i = 8'h00;
   logic [14:0] mem_addr;

   always #(CLKNS/2) clk = ~clk;

   sram_async_ctrl #(
      .CLK_NS (CLKNS), .T_RC_NS (RC), .T_AA_NS (AA), .T_OE_NS (OEN), .T_WC_NS (WC),
      .T_WP_NS (WPN), .T_DW_NS (DW), .T_AW_NS (AW), .T_OHZ_NS (OHZ), .T_REC_NS (RECN)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
      .rd_valid (rd_valid), .rd_data (rd_data), .retain (retain),
      .mem_addr (mem_addr), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
      .mem_dq_i (mem_dq_i), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n)
   );

   int checks = 0, fails = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- memory pin model ----------------
   logic [7:0]  smem [int];
   int          rd_age = 0;
   logic [14:0] last_a = '0;
   logic        prev_we_n = 1'b1;

   always @(negedge clk) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
         if (rd_age > 0 && mem_addr == last_a) rd_age++;
         else rd_age = 1;
      end else begin
         rd_age = 0;
      end
      last_a = mem_addr;
      if (rd_age >= RD_N && smem.exists(int'(mem_addr))) mem_dq_i <= smem[int'(mem_addr)];
      else mem_dq_i <= 8'h00;
      if (!prev_we_n && mem_we_n && !mem_ce_n && mem_dq_oe) smem[int'(mem_addr)] = mem_dq_o;
      prev_we_n = mem_we_n;
   end

   // ---------------- cycle reference model ----------------
   // word bits: {ce_n, oe_n, we_n, drive, ready, rd_valid}
   logic [5:0]  eq [$];
   logic [14:0] aq [$];
   logic [7:0]  dq [$];
   string       tq [$];
   logic [7:0]  rq [$];
   logic [7:0]  refmem [int];
   bit          model_on = 1'b0;
   bit          in_ret = 1'b0;
   int          rec_left = 0;

   task automatic push_seq(input bit w, input logic [14:0] a, input logic [7:0] d);
      if (w) begin
         for (int i = 0; i < WP_N; i++) begin
            eq.push_back(6'b010100); aq.push_back(a); dq.push_back(d); tq.push_back("R4");
         end
         for (int i = 0; i < TAIL_N; i++) begin
            eq.push_back(6'b011100); aq.push_back(a); dq.push_back(d); tq.push_back("R5");
         end
         refmem[int'(a)] = d;
      end else begin
         for (int i = 0; i < RD_N; i++) begin
            eq.push_back(6'b001000); aq.push_back(a); dq.push_back(8'h00); tq.push_back("R2");
         end
         for (int i = 0; i < TURN_N; i++) begin
            eq.push_back({5'b11100, (i == 0)}); aq.push_back(a); dq.push_back(8'h00); tq.push_back("R6");
         end
         rq.push_back(refmem.exists(int'(a)) ? refmem[int'(a)] : 8'h00);
      end
   endtask

   always @(negedge clk) begin
      if (model_on) begin
         logic [5:0]  act;
         logic [5:0]  e;
         logic [14:0] a;
         logic [7:0]  d;
         string       t;
         act = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid};
         if (eq.size() > 0) begin
            e = eq.pop_front(); a = aq.pop_front(); d = dq.pop_front(); t = tq.pop_front();
            chk(t, 32'(act), 32'(e));
            if (!e[5]) chk(t, 32'(mem_addr), 32'(a));
            if (e[2])  chk(t, 32'(mem_dq_o), 32'(d));
            if (e[0] && rq.size() > 0) chk("R3", 32'(rd_data), 32'(rq.pop_front()));
         end else begin
            e = {4'b1110, (!retain && !in_ret && rec_left == 0), 1'b0};
            t = in_ret ? "R8" : ((rec_left > 0) ? "R9" : "R7");
            chk(t, 32'(act), 32'(e));
            if (in_ret) begin
               if (!retain) begin in_ret = 1'b0; rec_left = REC_N; end
            end else if (rec_left > 0) begin
               if (retain) begin in_ret = 1'b1; rec_left = 0; end
               else rec_left--;
            end else if (retain) begin
               in_ret = 1'b1;
            end else if (req_valid) begin
               push_seq(req_write, req_addr, req_wdata);
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic req(input bit w, input logic [14:0] a, input logic [7:0] d);
      @(posedge clk); #2;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (eq.size() > 0 || in_ret || rec_left > 0) @(posedge clk);
      repeat (3) @(posedge clk);
      #2;
   endtask

   task automatic ticks(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}), 32'(5'b11100));
      @(posedge clk); #2;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 32'({req_ready, mem_ce_n, mem_dq_oe}), 32'(3'b110));
      model_on = 1'b1;

      // writes: back to back, corner addresses and data
      req(1, 15'h0000, 8'h5A);
      req(1, 15'h7FFF, 8'hA5);
      req(1, 15'h1234, 8'hFF);
      req(1, 15'h0001, 8'h00);
      // reads of each
      req(0, 15'h0000, 8'h00);
      req(0, 15'h7FFF, 8'h00);
      req(0, 15'h1234, 8'h00);
      req(0, 15'h0001, 8'h00);
      // read then write then read on one address
      req(0, 15'h1234, 8'h00);
      req(1, 15'h1234, 8'h3C);
      req(0, 15'h1234, 8'h00);
      req(1, 15'h5555, 8'h96);
      req(0, 15'h5555, 8'h00);
      drain();

      // R8/R9: retention from idle with a request held across it
      retain = 1'b1;
      ticks(20);
      fork req(1, 15'h2AAA, 8'h69); join_none
      ticks(10);
      retain = 1'b0;
      ticks(REC_N + 20);
      drain();
      req(0, 15'h2AAA, 8'h00);
      drain();

      // R9: retention re-raised inside the recovery window
      retain = 1'b1;
      ticks(8);
      retain = 1'b0;
      ticks(100);
      retain = 1'b1;
      ticks(5);
      retain = 1'b0;
      fork req(0, 15'h7FFF, 8'h00); join_none
      ticks(REC_N + 30);
      drain();

      // R8: retention raised during an access lets it finish
      fork req(1, 15'h0100, 8'hC3); join_none
      ticks(4);
      retain = 1'b1;
      ticks(25);
      retain = 1'b0;
      drain();
      req(0, 15'h0100, 8'h00);
      drain();

      chk("R7", 32'(req_ready), 32'(1));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLKNS * 150000);
      checks++;
      fails++;
      $display("FAIL R7: watchdog expired, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule